// File: doc/BRIEF.md
# Serial Debug Command Engine

This block turns a stream of received bytes into debug operations on a target. It waits behind a byte-wide serial receiver and expects a link-open byte first. After that it decodes a one-byte opcode and gathers the parameters that follow it. It then runs a single access or a loop of accesses on a shared word bus. That bus selects one of four spaces: internal RAM, system memory, I/O and DSP parameter RAM. Read data goes back through a byte transmitter with a valid/ready handshake. Most write-type commands are answered with a fixed acknowledge byte.

Page writes to the on-chip flash are acknowledged as soon as the last word has gone out on the bus. A separate poll command holds its acknowledge until the flash reports idle. A breakpoint event queues an unsolicited two-byte marker, which is sent once the engine is idle. Jump and resume commands raise single-cycle strobes towards the control processor and send no reply.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset, every received byte is ignored (no reply, no bus access) until 0xF0 arrives. 0xF0 is answered with the single byte 0xAC, in the unlinked state and at any later idle point.
- R2: Opcodes 0x00 (1-byte address, space 0), 0x02 (4-byte address, space 1) and 0x04 (1-byte address, space 2) perform one bus read. The reply is the low 16 bits of read data, sent low byte first then high byte. Space codes are 0 internal RAM, 1 system memory, 2 I/O and 3 DSP RAM.
- R3: Opcodes 0x01 (address, 2 data bytes), 0x03 (4-byte address, 2 data bytes) and 0x05 (I/O address, 2 data bytes) perform one bus write. 0xAC is sent only after the bus has accepted the write.
- R4: Every multi-byte address, size or data field arrives least significant byte first.
- R5: Opcodes 0x06 and 0x07 read space 3 at a 2-byte address and return bits 15:0 or bits 31:16 of the bus data. Opcode 0x08 writes a 32-bit word from four data bytes to space 3 and answers 0xAC.
- R6: Opcode 0x0B (4-byte address, 2-byte size N) reads N consecutive words of space 1 and sends 2N bytes with no acknowledge.
- R7: Opcode 0x0C (4-byte address, size N, then 2N data bytes) writes N consecutive words of space 1 and sends one 0xAC after the last write.
- R8: Opcode 0x0D (2-byte offset, 1-byte size N, then 2N data bytes) writes N words to space 1 starting at 0x8000 plus the offset. It sends 0xAC once the last write is accepted, whatever the flash busy input says.
- R9: A 0x0D request is dropped without a reply or any bus access when N is 0, N exceeds 32, or offset[4:0]+N exceeds 32. An offset of 0x1C with N=4 is accepted.
- R10: Opcode 0x0E takes one dummy byte and sends 0xAC only once the flash busy input is low.
- R11: Opcode 0x09 (2-byte address) pulses the jump strobe with that address. Opcode 0x0A (one dummy byte) pulses the resume strobe. Neither sends any byte.
- R12: A breakpoint pulse makes the engine send 0xAA then 0x55 when it is next idle.
- R13: An unknown opcode is dropped without reply, and the next byte is decoded as a fresh opcode.
- R14: Bytes received while a reply is pending are ignored. A held transmit byte stays stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe, one cycle per byte |
| tx_data_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| mem_req_o | output | 1 | Bus access request, held until ready |
| mem_we_o | output | 1 | Bus write (1) or read (0) |
| mem_space_o | output | 2 | Address space select |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| flash_busy_i | input | 1 | Flash programming in progress |
| bp_hit_i | input | 1 | Breakpoint reached pulse |
| go_o | output | 1 | Jump strobe |
| go_addr_o | output | 16 | Jump target |
| resume_o | output | 1 | Resume strobe |

## Verification
The checks assume a bus slave that holds ready for at most one cycle per request and returns data in that cycle. They also assume the host sends at most one byte per cycle on the receive strobe and paces data words so that each one arrives after the previous write has finished. The stimulus drives one byte every other cycle and waits several cycles after each data word. It changes transmit readiness only at negative edges, so a held byte is seen stable on the next rising edge.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam logic [7:0] OP_RD_IRAM  = 8'h00;
  localparam logic [7:0] OP_WR_IRAM  = 8'h01;
  localparam logic [7:0] OP_RD_MEM   = 8'h02;
  localparam logic [7:0] OP_WR_MEM   = 8'h03;
  localparam logic [7:0] OP_RD_IO    = 8'h04;
  localparam logic [7:0] OP_WR_IO    = 8'h05;
  localparam logic [7:0] OP_RD_DSPL  = 8'h06;
  localparam logic [7:0] OP_RD_DSPH  = 8'h07;
  localparam logic [7:0] OP_WR_DSP   = 8'h08;
  localparam logic [7:0] OP_JUMP     = 8'h09;
  localparam logic [7:0] OP_RESUME   = 8'h0A;
  localparam logic [7:0] OP_BLK_RD   = 8'h0B;
  localparam logic [7:0] OP_BLK_WR   = 8'h0C;
  localparam logic [7:0] OP_FL_WR    = 8'h0D;
  localparam logic [7:0] OP_FL_CHK   = 8'h0E;
  localparam logic [7:0] OP_LINK     = 8'hF0;
  localparam logic [7:0] ACK_BYTE    = 8'hAC;
  localparam logic [7:0] BRK_BYTE0   = 8'hAA;
  localparam logic [7:0] BRK_BYTE1   = 8'h55;

  typedef enum logic [1:0] {SP_IRAM, SP_XMEM, SP_IO, SP_DSP} space_e;
  typedef enum logic [2:0] {
    S_LINK, S_IDLE, S_PARAM, S_EXEC, S_DATA, S_BUS, S_TX, S_FWAIT
  } state_e;
endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode import dbg_cmd_pkg::*; (
  input  logic [7:0] op_i,
  output logic       known_o,
  output logic [2:0] nparam_o,
  output space_e     space_o,
  output logic       write_o
);
  always_comb begin
    known_o  = 1'b1;
    nparam_o = 3'd0;
    space_o  = SP_IRAM;
    write_o  = 1'b0;
    unique case (op_i)
      OP_RD_IRAM: nparam_o = 3'd1;
      OP_WR_IRAM: begin nparam_o = 3'd3; write_o = 1'b1; end
      OP_RD_MEM:  begin nparam_o = 3'd4; space_o = SP_XMEM; end
      OP_WR_MEM:  begin nparam_o = 3'd6; space_o = SP_XMEM; write_o = 1'b1; end
      OP_RD_IO:   begin nparam_o = 3'd1; space_o = SP_IO; end
      OP_WR_IO:   begin nparam_o = 3'd3; space_o = SP_IO; write_o = 1'b1; end
      OP_RD_DSPL,
      OP_RD_DSPH: begin nparam_o = 3'd2; space_o = SP_DSP; end
      OP_WR_DSP:  begin nparam_o = 3'd6; space_o = SP_DSP; write_o = 1'b1; end
      OP_JUMP:    nparam_o = 3'd2;
      OP_RESUME:  nparam_o = 3'd1;
      OP_BLK_RD:  begin nparam_o = 3'd6; space_o = SP_XMEM; end
      OP_BLK_WR:  begin nparam_o = 3'd6; space_o = SP_XMEM; write_o = 1'b1; end
      OP_FL_WR:   begin nparam_o = 3'd3; space_o = SP_XMEM; write_o = 1'b1; end
      OP_FL_CHK:  nparam_o = 3'd1;
      default:    known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_param_shift.sv
module dbg_param_shift #(
  parameter int NBYTES = 6,
  localparam int CW = $clog2(NBYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [7:0]        byte_i,
  output logic [CW-1:0]     cnt_o,
  output logic [NBYTES*8-1:0] params_o
);
  logic [CW-1:0] cnt_q;
  logic [NBYTES*8-1:0] prm_q;

  // incoming bytes fill from the low end: little-endian fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      prm_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      prm_q[cnt_q*8 +: 8] <= byte_i;
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign params_o = prm_q;

  // R4
  param_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !clr_i |-> cnt_q < CW'(NBYTES));
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine import dbg_cmd_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int PAGE_WORDS = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 'h8000,
  parameter int MAX_PARAM = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_space_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ready_i,
  input  logic              flash_busy_i,
  input  logic              bp_hit_i,
  output logic              go_o,
  output logic [15:0]       go_addr_o,
  output logic              resume_o
);
  localparam int CW   = $clog2(MAX_PARAM + 1);
  localparam int PG_W = $clog2(PAGE_WORDS);

  state_e            state_q;
  logic [7:0]        op_q;
  logic [CW-1:0]     need_q;
  logic [15:0]       words_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q;
  logic              we_q;
  space_e            space_q;
  logic [15:0]       txbuf_q;
  logic [1:0]        txleft_q;
  logic              bp_tx_q;
  logic              bp_pend_q;
  logic              lo_have_q;
  logic [7:0]        lo_q;
  logic              go_q, resume_q;
  logic [15:0]       go_addr_q;

  logic              rx_known, dx_known, rx_wr, dx_wr;
  logic [2:0]        rx_np, dx_np;
  space_e            rx_sp, dx_sp;
  logic [CW-1:0]     pcnt;
  logic [MAX_PARAM*8-1:0] prm;

  dbg_op_decode u_rx_dec (
    .op_i(rx_data_i), .known_o(rx_known), .nparam_o(rx_np),
    .space_o(rx_sp), .write_o(rx_wr));

  dbg_op_decode u_op_dec (
    .op_i(op_q), .known_o(dx_known), .nparam_o(dx_np),
    .space_o(dx_sp), .write_o(dx_wr));

  dbg_param_shift #(.NBYTES(MAX_PARAM)) u_prm (
    .clk_i, .rst_ni,
    .clr_i(state_q == S_IDLE),
    .push_i(state_q == S_PARAM && rx_valid_i),
    .byte_i(rx_data_i),
    .cnt_o(pcnt),
    .params_o(prm));

  // flash page rule
  logic [7:0]  fl_size;
  logic [31:0] fl_end;
  logic        fl_ok;
  always_comb begin
    fl_size = prm[23:16];
    fl_end  = 32'(prm[PG_W-1:0]) + 32'(fl_size);
    fl_ok   = (fl_size != 8'd0) && (32'(fl_size) <= 32'(PAGE_WORDS)) &&
              (fl_end <= 32'(PAGE_WORDS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_LINK;
      op_q      <= '0;
      need_q    <= '0;
      words_q   <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      space_q   <= SP_IRAM;
      txbuf_q   <= '0;
      txleft_q  <= '0;
      bp_tx_q   <= 1'b0;
      bp_pend_q <= 1'b0;
      lo_have_q <= 1'b0;
      lo_q      <= '0;
      go_q      <= 1'b0;
      resume_q  <= 1'b0;
      go_addr_q <= '0;
    end else begin
      go_q     <= 1'b0;
      resume_q <= 1'b0;
      if (bp_hit_i) bp_pend_q <= 1'b1;
      unique case (state_q)
        S_LINK: if (rx_valid_i && rx_data_i == OP_LINK) begin
          txbuf_q <= {8'h00, ACK_BYTE}; txleft_q <= 2'd1; state_q <= S_TX;
        end
        S_IDLE: begin
          if (rx_valid_i) begin
            op_q <= rx_data_i;
            if (rx_data_i == OP_LINK) begin
              txbuf_q <= {8'h00, ACK_BYTE}; txleft_q <= 2'd1; state_q <= S_TX;
            end else if (rx_known) begin
              need_q  <= CW'(rx_np);
              state_q <= S_PARAM;
            end
          end else if (bp_pend_q) begin
            txbuf_q   <= {BRK_BYTE1, BRK_BYTE0};
            txleft_q  <= 2'd2;
            bp_tx_q   <= 1'b1;
            bp_pend_q <= 1'b0;
            state_q   <= S_TX;
          end
        end
        S_PARAM: if (rx_valid_i && pcnt + CW'(1) == need_q) state_q <= S_EXEC;
        S_EXEC: begin
          we_q      <= dx_wr;
          space_q   <= dx_sp;
          lo_have_q <= 1'b0;
          unique case (op_q)
            OP_RD_IRAM, OP_WR_IRAM, OP_RD_IO, OP_WR_IO: begin
              addr_q  <= ADDR_W'(prm[7:0]);
              wdata_q <= 32'(prm[23:8]);
              state_q <= S_BUS;
            end
            OP_RD_MEM, OP_WR_MEM: begin
              addr_q  <= ADDR_W'(prm[31:0]);
              wdata_q <= 32'(prm[47:32]);
              state_q <= S_BUS;
            end
            OP_RD_DSPL, OP_RD_DSPH, OP_WR_DSP: begin
              addr_q  <= ADDR_W'(prm[15:0]);
              wdata_q <= prm[47:16];
              state_q <= S_BUS;
            end
            OP_BLK_RD, OP_BLK_WR: begin
              addr_q  <= ADDR_W'(prm[31:0]);
              words_q <= prm[47:32];
              if (prm[47:32] != 16'd0)
                state_q <= (op_q == OP_BLK_RD) ? S_BUS : S_DATA;
              else if (op_q == OP_BLK_WR) begin
                txbuf_q <= {8'h00, ACK_BYTE}; txleft_q <= 2'd1; state_q <= S_TX;
              end else
                state_q <= S_IDLE;
            end
            OP_FL_WR: begin
              addr_q  <= FLASH_BASE + ADDR_W'(prm[15:0]);
              words_q <= 16'(fl_size);
              state_q <= fl_ok ? S_DATA : S_IDLE;
            end
            OP_JUMP: begin
              go_q      <= 1'b1;
              go_addr_q <= prm[15:0];
              state_q   <= S_IDLE;
            end
            OP_RESUME: begin
              resume_q <= 1'b1;
              state_q  <= S_IDLE;
            end
            OP_FL_CHK: state_q <= S_FWAIT;
            default:   state_q <= S_IDLE;
          endcase
        end
        S_DATA: if (rx_valid_i) begin
          if (!lo_have_q) begin
            lo_q      <= rx_data_i;
            lo_have_q <= 1'b1;
          end else begin
            wdata_q   <= 32'({rx_data_i, lo_q});
            lo_have_q <= 1'b0;
            state_q   <= S_BUS;
          end
        end
        S_BUS: if (mem_ready_i) begin
          addr_q  <= addr_q + ADDR_W'(1);
          words_q <= words_q - 16'd1;
          if (!we_q) begin
            txbuf_q  <= (op_q == OP_RD_DSPH) ? mem_rdata_i[31:16] : mem_rdata_i[15:0];
            txleft_q <= 2'd2;
            state_q  <= S_TX;
          end else if ((op_q == OP_BLK_WR || op_q == OP_FL_WR) && words_q != 16'd1) begin
            state_q <= S_DATA;
          end else begin
            txbuf_q <= {8'h00, ACK_BYTE}; txleft_q <= 2'd1; state_q <= S_TX;
          end
        end
        S_TX: if (tx_ready_i) begin
          txbuf_q  <= {8'h00, txbuf_q[15:8]};
          txleft_q <= txleft_q - 2'd1;
          if (txleft_q == 2'd1) begin
            bp_tx_q <= 1'b0;
            state_q <= (op_q == OP_BLK_RD && words_q != 16'd0 && !bp_tx_q) ? S_BUS : S_IDLE;
          end
        end
        S_FWAIT: if (!flash_busy_i) begin
          txbuf_q <= {8'h00, ACK_BYTE}; txleft_q <= 2'd1; state_q <= S_TX;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tx_valid_o  = (state_q == S_TX);
  assign tx_data_o   = txbuf_q[7:0];
  assign mem_req_o   = (state_q == S_BUS);
  assign mem_we_o    = we_q;
  assign mem_space_o = space_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign go_o        = go_q;
  assign go_addr_o   = go_addr_q;
  assign resume_o    = resume_q;

  // R14
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  // R3
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R10
  fl_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_FWAIT && flash_busy_i |=> !tx_valid_o);
  // R12
  brk_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && bp_tx_q && txleft_q == 2'd2 |=> tx_valid_o && tx_data_o == BRK_BYTE1);
  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> !resume_o && !tx_valid_o);
endmodule

// File: tb/dbg_cmd_engine_test.sv
module dbg_cmd_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_rdy = 1'b1;
  logic mem_req, mem_we;
  logic [1:0] mem_space;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ready = 1'b0;
  logic flash_busy = 1'b0;
  logic bp_hit = 1'b0;
  logic go, resume;
  logic [15:0] go_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_rdy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_space_o(mem_space),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .flash_busy_i(flash_busy), .bp_hit_i(bp_hit),
    .go_o(go), .go_addr_o(go_addr), .resume_o(resume));

  int checks = 0, fails = 0;
  int tx_n = 0, acc_n = 0, go_n = 0, res_n = 0;
  logic [7:0]  tx_log [0:63];
  logic [1:0]  acc_sp [0:15];
  logic        acc_we [0:15];
  logic [31:0] acc_ad [0:15];
  logic [31:0] acc_wd [0:15];
  logic [15:0] go_seen = '0;
  int lat = 0, lat_cnt = 0;

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    return {a[15:0] + 16'h0101, a[15:0] ^ 16'hA5C3};
  endfunction

  // bus slave and port monitors, all at the falling edge
  always @(negedge clk) begin
    if (tx_valid && tx_rdy) begin tx_log[tx_n % 64] <= tx_data; tx_n <= tx_n + 1; end
    if (go) begin go_n <= go_n + 1; go_seen <= go_addr; end
    if (resume) res_n <= res_n + 1;
    if (mem_ready) mem_ready <= 1'b0;
    else if (mem_req) begin
      if (lat_cnt >= lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= model_rd(mem_addr);
        lat_cnt <= 0;
        acc_sp[acc_n % 16] <= mem_space; acc_we[acc_n % 16] <= mem_we;
        acc_ad[acc_n % 16] <= mem_addr;  acc_wd[acc_n % 16] <= mem_wdata;
        acc_n <= acc_n + 1;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    send(w[7:0]); send(w[15:8]);
    repeat (8) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    @(negedge clk); tx_n = 0; acc_n = 0; go_n = 0; res_n = 0;
  endtask

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  np;
    logic [47:0] prm;
    logic [1:0]  sp;
    logic [31:0] ad;
  } rd_vec_t;

  localparam rd_vec_t RD_VECS [5] = '{
    '{8'h00, 3'd1, 48'h12,        2'd0, 32'h12},
    '{8'h02, 3'd4, 48'h12345678,  2'd1, 32'h12345678},
    '{8'h04, 3'd1, 48'h40,        2'd2, 32'h40},
    '{8'h06, 3'd2, 48'h1234,      2'd3, 32'h1234},
    '{8'h07, 3'd2, 48'hBEEF,      2'd3, 32'hBEEF}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    chk(!tx_valid && !mem_req && !go && !resume, "reset", {tx_valid, mem_req}, 0);

    // R1: bytes before link are dropped
    send(8'h00); send(8'h10); idle(10);
    chk(tx_n == 0 && acc_n == 0, "R1 unlinked", tx_n + acc_n, 0);
    send(8'hF0); idle(5);
    chk(tx_n == 1 && tx_log[0] == 8'hAC, "R1 link ack", tx_log[0], 8'hAC);

    // R2 R4 R5 reads from the table
    foreach (RD_VECS[i]) begin
      logic [31:0] rd;
      logic [15:0] exp;
      clear_logs();
      send(RD_VECS[i].op);
      for (int k = 0; k < int'(RD_VECS[i].np); k++) send(RD_VECS[i].prm[k*8 +: 8]);
      idle(10);
      rd  = model_rd(RD_VECS[i].ad);
      exp = (RD_VECS[i].op == 8'h07) ? rd[31:16] : rd[15:0];
      chk(acc_n == 1 && !acc_we[0] && acc_sp[0] == RD_VECS[i].sp && acc_ad[0] == RD_VECS[i].ad,
          "R2 R4 read access", {acc_sp[0], acc_ad[0]}, {RD_VECS[i].sp, RD_VECS[i].ad});
      chk(tx_n == 2 && {tx_log[1], tx_log[0]} == exp, "R2 R5 reply order",
          {tx_log[1], tx_log[0]}, exp);
    end

    // R3: IRAM write
    clear_logs();
    send(8'h01); send(8'h33); send(8'hCD); send(8'hAB); idle(10);
    chk(acc_n == 1 && acc_we[0] && acc_sp[0] == 2'd0 && acc_ad[0] == 32'h33 && acc_wd[0][15:0] == 16'hABCD,
        "R3 iram write", {acc_ad[0], acc_wd[0]}, {32'h33, 32'hABCD});
    chk(tx_n == 1 && tx_log[0] == 8'hAC, "R3 iram ack", tx_log[0], 8'hAC);

    // R3: memory write with slow bus, ack waits for completion
    clear_logs(); lat = 6;
    send(8'h03); send(8'h04); send(8'h03); send(8'h02); send(8'h01); send(8'h22); send(8'h11);
    idle(4);
    chk(tx_n == 0, "R3 ack held for bus", tx_n, 0);
    idle(12);
    chk(acc_n == 1 && acc_ad[0] == 32'h01020304 && acc_wd[0][15:0] == 16'h1122 && acc_sp[0] == 2'd1,
        "R3 R4 mem write", acc_ad[0], 32'h01020304);
    chk(tx_n == 1 && tx_log[0] == 8'hAC, "R3 mem ack", tx_log[0], 8'hAC);
    lat = 0;

    // R3: I/O write
    clear_logs();
    send(8'h05); send(8'h09); send(8'h78); send(8'h56); idle(10);
    chk(acc_n == 1 && acc_sp[0] == 2'd2 && acc_ad[0] == 32'h9 && acc_wd[0][15:0] == 16'h5678 && tx_log[0] == 8'hAC,
        "R3 io write", {acc_sp[0], acc_wd[0]}, {2'd2, 32'h5678});

    // R5: DSP 32-bit write
    clear_logs();
    send(8'h08); send(8'h10); send(8'h00); send(8'h44); send(8'h33); send(8'h22); send(8'h11); idle(10);
    chk(acc_n == 1 && acc_sp[0] == 2'd3 && acc_ad[0] == 32'h10 && acc_wd[0] == 32'h11223344 && tx_log[0] == 8'hAC,
        "R5 dsp write", acc_wd[0], 32'h11223344);

    // R6: block read of 3 words
    clear_logs();
    send(8'h0B); send(8'h00); send(8'h01); send(8'h00); send(8'h00); send(8'h03); send(8'h00); idle(30);
    chk(tx_n == 6 && acc_n == 3, "R6 block count", tx_n, 6);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] rd;
      rd = model_rd(32'h100 + 32'(w));
      chk({tx_log[2*w+1], tx_log[2*w]} == rd[15:0] && acc_ad[w] == 32'h100 + 32'(w),
          "R6 block data", {tx_log[2*w+1], tx_log[2*w]}, rd[15:0]);
    end

    // R7: block write of 2 words
    clear_logs();
    send(8'h0C); send(8'h00); send(8'h02); send(8'h00); send(8'h00); send(8'h02); send(8'h00);
    send_word(16'hA1A2);
    chk(tx_n == 0, "R7 no early ack", tx_n, 0);
    send_word(16'hB1B2);
    chk(acc_n == 2 && acc_ad[0] == 32'h200 && acc_ad[1] == 32'h201 && acc_wd[1][15:0] == 16'hB1B2,
        "R7 block write", acc_wd[1], 32'hB1B2);
    chk(tx_n == 1 && tx_log[0] == 8'hAC, "R7 block ack", tx_n, 1);

    // R8: flash page write, acked while still busy
    clear_logs(); flash_busy = 1'b1;
    send(8'h0D); send(8'h04); send(8'h00); send(8'h02);
    send_word(16'h1111); send_word(16'h2222);
    chk(acc_n == 2 && acc_ad[0] == 32'h8004 && acc_ad[1] == 32'h8005 && acc_sp[1] == 2'd1 && acc_wd[1][15:0] == 16'h2222,
        "R8 flash writes", acc_ad[1], 32'h8005);
    chk(tx_n == 1 && tx_log[0] == 8'hAC, "R8 early ack", tx_n, 1);

    // R10: poll waits for not-busy
    clear_logs();
    send(8'h0E); send(8'h00); idle(20);
    chk(tx_n == 0, "R10 held while busy", tx_n, 0);
    flash_busy = 1'b0; idle(5);
    chk(tx_n == 1 && tx_log[0] == 8'hAC, "R10 ack after idle", tx_n, 1);

    // R9: size and page violations dropped
    clear_logs();
    send(8'h0D); send(8'h00); send(8'h00); send(8'h21); idle(6);
    send(8'h0D); send(8'h1E); send(8'h00); send(8'h04); idle(6);
    send(8'h0D); send(8'h00); send(8'h00); send(8'h00); idle(6);
    chk(tx_n == 0 && acc_n == 0, "R9 dropped", tx_n + acc_n, 0);
    send(8'hF0); idle(5);
    chk(tx_n == 1 && tx_log[0] == 8'hAC, "R9 back to idle", tx_log[0], 8'hAC);
    clear_logs();
    send(8'h0D); send(8'h1C); send(8'h00); send(8'h04);
    for (int w = 0; w < 4; w++) send_word(16'(w));
    chk(acc_n == 4 && acc_ad[3] == 32'h801F && tx_n == 1, "R9 page edge accepted", acc_ad[3], 32'h801F);

    // R13: unknown opcode
    clear_logs();
    send(8'h20); idle(4);
    send(8'h00); send(8'h05); idle(10);
    chk(acc_n == 1 && acc_ad[0] == 32'h5 && tx_n == 2, "R13 unknown dropped", acc_n, 1);

    // R11: jump and resume
    clear_logs();
    send(8'h09); send(8'hCD); send(8'hAB); idle(6);
    chk(go_n == 1 && go_seen == 16'hABCD && tx_n == 0, "R11 jump", go_seen, 16'hABCD);
    send(8'h0A); send(8'h00); idle(6);
    chk(res_n == 1 && tx_n == 0 && acc_n == 0, "R11 resume", res_n, 1);

    // R12: breakpoint marker
    clear_logs();
    @(negedge clk); bp_hit = 1'b1; @(negedge clk); bp_hit = 1'b0;
    idle(8);
    chk(tx_n == 2 && tx_log[0] == 8'hAA && tx_log[1] == 8'h55, "R12 marker",
        {tx_log[0], tx_log[1]}, 16'hAA55);

    // R14: bytes during a stalled reply
    clear_logs(); tx_rdy = 1'b0;
    send(8'h00); send(8'h21); idle(5);
    send(8'h00); send(8'h22); idle(5);
    tx_rdy = 1'b1; idle(10);
    begin
      logic [31:0] rd;
      rd = model_rd(32'h21);
      chk(tx_n == 2 && acc_n == 1 && {tx_log[1], tx_log[0]} == rd[15:0], "R14 ignored during reply",
          {tx_n, acc_n}, {32'd2, 32'd1});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule